// File: doc/BRIEF.md
# Host-to-Controller Byte Mailbox

This block is a small register file shared by two agents. The host reaches it through a byte-wide I/O port. The port decodes a window of 2^OFF_W bytes placed at the parameter `BASE` in the host's I/O space. The controller reaches the same registers through a second byte port that carries only the offset inside the window.

A transaction runs in this order. The host fills the bank of byte data registers with a request, clears any stale response flag and rings a doorbell. The doorbell holds a level interrupt toward the controller. The controller reads the request and writes its reply over the same data registers. It then silences the doorbell and sets the response flag. That flag holds a level interrupt toward the host until the host writes one to clear it. The host can also poll the flag. The block does not interpret the bytes of a message.

Top module: `hb_mailbox`

## Requirements
- R1: After reset, every data register reads 0x00, the doorbell and response flags read 0, and `hostIrq` and `ctrlIrq` are low.
- R2: Offsets 0 to NUM_DATA-1 (0x00 to 0x0F by default) are byte data registers that either port can write. A byte written by one port can be read back by both ports. Read data appears on the rising edge that samples the read strobe and holds 0x00 in any cycle without a read strobe.
- R3: If both ports write the same data offset in the same cycle, the controller's byte is the one kept.
- R4: A host write to the doorbell offset (NUM_DATA, 0x10) stores bit 0 of the byte. 1 rings the doorbell and 0 withdraws it. `ctrlIrq` equals the stored doorbell bit from the next cycle on.
- R5: A controller write to the doorbell offset with bit 0 set clears the doorbell, and with bit 0 clear it has no effect. When a host write to the doorbell happens in the same cycle, the host write wins.
- R6: A controller write to the status offset (NUM_DATA+1, 0x11) with bit 0 set sets the response flag. `hostIrq` equals the response flag. A controller write with bit 0 clear has no effect.
- R7: A host write to the status offset with bit 0 set clears the response flag, and with bit 0 clear it has no effect. A controller set in the same cycle wins over a host clear.
- R8: A read of the status offset returns the response flag in bit 0. A read of the doorbell offset returns the doorbell bit in bit 0. All other bits of both reads are 0.
- R9: Host addresses outside [BASE, BASE+2^OFF_W) and offsets above the status offset read as 0x00, and writes to them change nothing.
- R10: A read and a write to the same register in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | IO_W | Host I/O address |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Host read byte, registered |
| ctrlAddr | input | OFF_W | Controller offset in the window |
| ctrlWr | input | 1 | Controller write strobe |
| ctrlRd | input | 1 | Controller read strobe |
| ctrlWrData | input | 8 | Controller write byte |
| ctrlRdData | output | 8 | Controller read byte, registered |
| hostIrq | output | 1 | Level interrupt to host, response flag |
| ctrlIrq | output | 1 | Level interrupt to controller, doorbell |

## Verification
Every result of this block is due exactly one rising edge after the strobe that causes it. This covers read bytes, the doorbell and response flags, and both interrupts. The bench drives strobes on the falling edge and updates its reference model for that single edge. It then samples both read buses and both interrupts 1 ns after the next rising edge, before any new stimulus. Same-cycle read-and-write steps check that a read returns the value held before the write. Collision steps check the priority orders. Idle steps check that the read buses return to zero.

// File: rtl/hbm_pkg.sv
package hbm_pkg;

  // Source picked for a registered read bus
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_BELL = 2'd2,
    SEL_RESP = 2'd3
  } rdSel_e;

  // Strobes from the decoder into the register datapath
  typedef struct packed {
    logic   hostDataWr;
    logic   ctrlDataWr;
    logic   hostBellWr;
    logic   ctrlBellClr;
    logic   hostRespClr;
    logic   ctrlRespSet;
    rdSel_e hostRdSel;
    rdSel_e ctrlRdSel;
  } strobe_t;

endpackage

// File: rtl/hbm_decode.sv
module hbm_decode
  import hbm_pkg::*;
#(
  parameter int IO_W     = 16,
  parameter int OFF_W    = 5,
  parameter int NUM_DATA = 16,
  parameter logic [IO_W-1:0] BASE = 16'h0C00,
  localparam int DIDX_W = $clog2(NUM_DATA)
) (
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [IO_W-1:0]   hostAddr,
  input  logic              hostBit0,
  input  logic              ctrlWr,
  input  logic              ctrlRd,
  input  logic [OFF_W-1:0]  ctrlAddr,
  input  logic              ctrlBit0,
  output strobe_t           strb,
  output logic [DIDX_W-1:0] hostIdx,
  output logic [DIDX_W-1:0] ctrlIdx
);

  localparam logic [OFF_W-1:0] BELL_OFF = OFF_W'(NUM_DATA);
  localparam logic [OFF_W-1:0] RESP_OFF = OFF_W'(NUM_DATA + 1);

  logic [IO_W:0]    hostRel;
  logic             hostHit;
  logic [OFF_W-1:0] hostOff;
  logic             hostIsData, hostIsBell, hostIsResp;
  logic             ctrlIsData, ctrlIsBell, ctrlIsResp;

  // An address below BASE wraps to a large value, so the upper bits reject it
  assign hostRel = {1'b0, hostAddr} - {1'b0, BASE};
  assign hostHit = (hostRel[IO_W:OFF_W] == '0);
  assign hostOff = hostRel[OFF_W-1:0];

  assign hostIsData = hostHit && (hostOff < BELL_OFF);
  assign hostIsBell = hostHit && (hostOff == BELL_OFF);
  assign hostIsResp = hostHit && (hostOff == RESP_OFF);
  assign ctrlIsData = (ctrlAddr < BELL_OFF);
  assign ctrlIsBell = (ctrlAddr == BELL_OFF);
  assign ctrlIsResp = (ctrlAddr == RESP_OFF);

  assign hostIdx = hostOff[DIDX_W-1:0];
  assign ctrlIdx = ctrlAddr[DIDX_W-1:0];

  function automatic rdSel_e pickSel(input logic rd, input logic isData,
                                     input logic isBell, input logic isResp);
    if (!rd)         return SEL_NONE;
    else if (isData) return SEL_DATA;
    else if (isBell) return SEL_BELL;
    else if (isResp) return SEL_RESP;
    else             return SEL_NONE;
  endfunction

  always_comb begin
    strb.hostDataWr  = hostWr && hostIsData;
    strb.ctrlDataWr  = ctrlWr && ctrlIsData;
    strb.hostBellWr  = hostWr && hostIsBell;
    strb.ctrlBellClr = ctrlWr && ctrlIsBell && ctrlBit0;
    strb.hostRespClr = hostWr && hostIsResp && hostBit0;
    strb.ctrlRespSet = ctrlWr && ctrlIsResp && ctrlBit0;
    strb.hostRdSel   = pickSel(hostRd, hostIsData, hostIsBell, hostIsResp);
    strb.ctrlRdSel   = pickSel(ctrlRd, ctrlIsData, ctrlIsBell, ctrlIsResp);
  end

endmodule

// File: rtl/hbm_datapath.sv
module hbm_datapath
  import hbm_pkg::*;
#(
  parameter int NUM_DATA = 16,
  localparam int DIDX_W = $clog2(NUM_DATA)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DIDX_W-1:0] hostIdx,
  input  logic [DIDX_W-1:0] ctrlIdx,
  input  logic [7:0]        hostWrData,
  input  logic [7:0]        ctrlWrData,
  output logic [7:0]        hostRdData,
  output logic [7:0]        ctrlRdData,
  output logic              bellQ,
  output logic              respQ
);

  logic [7:0] dataQ [NUM_DATA];

  // One byte register per offset; the controller's reply wins a collision
  for (genvar gi = 0; gi < NUM_DATA; gi++) begin : g_data
    always_ff @(posedge clk) begin
      if (!rstN)
        dataQ[gi] <= '0;
      else if (strb.ctrlDataWr && ctrlIdx == DIDX_W'(gi))
        dataQ[gi] <= ctrlWrData;
      else if (strb.hostDataWr && hostIdx == DIDX_W'(gi))
        dataQ[gi] <= hostWrData;
    end
  end

  // Doorbell: the host stores bit 0, the controller clears it, the host wins
  always_ff @(posedge clk) begin
    if (!rstN)                 bellQ <= 1'b0;
    else if (strb.hostBellWr)  bellQ <= hostWrData[0];
    else if (strb.ctrlBellClr) bellQ <= 1'b0;
  end

  // Response flag: the controller sets it, the host clears it, a set wins
  always_ff @(posedge clk) begin
    if (!rstN)                 respQ <= 1'b0;
    else if (strb.ctrlRespSet) respQ <= 1'b1;
    else if (strb.hostRespClr) respQ <= 1'b0;
  end

  function automatic logic [7:0] readMux(input rdSel_e sel, input logic [7:0] dataByte,
                                         input logic bell, input logic resp);
    case (sel)
      SEL_DATA: return dataByte;
      SEL_BELL: return {7'd0, bell};
      SEL_RESP: return {7'd0, resp};
      default:  return 8'd0;
    endcase
  endfunction

  // Reads see the state held before this edge's writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostRdData <= '0;
      ctrlRdData <= '0;
    end else begin
      hostRdData <= readMux(strb.hostRdSel, dataQ[hostIdx], bellQ, respQ);
      ctrlRdData <= readMux(strb.ctrlRdSel, dataQ[ctrlIdx], bellQ, respQ);
    end
  end

  AST_RESP_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.ctrlRespSet |=> respQ); // R6
  AST_RESP_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hostRespClr && !strb.ctrlRespSet) |=> !respQ); // R7
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.hostRespClr && !strb.ctrlRespSet) |=> $stable(respQ)); // R7
  AST_BELL_HOST: assert property (@(posedge clk) disable iff (!rstN)
    strb.hostBellWr |=> (bellQ == $past(hostWrData[0]))); // R4
  AST_BELL_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctrlBellClr && !strb.hostBellWr) |=> !bellQ); // R5
  AST_HOST_RD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hostRdSel == SEL_NONE) |=> (hostRdData == 8'd0)); // R9
  AST_CTRL_RD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ctrlRdSel == SEL_NONE) |=> (ctrlRdData == 8'd0)); // R2

endmodule

// File: rtl/hb_mailbox.sv
module hb_mailbox
  import hbm_pkg::*;
#(
  parameter int IO_W     = 16,
  parameter int OFF_W    = 5,
  parameter int NUM_DATA = 16,
  parameter logic [IO_W-1:0] BASE = 16'h0C00,
  localparam int DIDX_W = $clog2(NUM_DATA)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IO_W-1:0]  hostAddr,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic [7:0]       hostWrData,
  output logic [7:0]       hostRdData,
  input  logic [OFF_W-1:0] ctrlAddr,
  input  logic             ctrlWr,
  input  logic             ctrlRd,
  input  logic [7:0]       ctrlWrData,
  output logic [7:0]       ctrlRdData,
  output logic             hostIrq,
  output logic             ctrlIrq
);

  strobe_t           strb;
  logic [DIDX_W-1:0] hostIdx, ctrlIdx;
  logic              bellQ, respQ;

  hbm_decode #(
    .IO_W(IO_W), .OFF_W(OFF_W), .NUM_DATA(NUM_DATA), .BASE(BASE)
  ) uDecode (
    .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr), .hostBit0(hostWrData[0]),
    .ctrlWr(ctrlWr), .ctrlRd(ctrlRd), .ctrlAddr(ctrlAddr), .ctrlBit0(ctrlWrData[0]),
    .strb(strb), .hostIdx(hostIdx), .ctrlIdx(ctrlIdx)
  );

  hbm_datapath #(.NUM_DATA(NUM_DATA)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostIdx(hostIdx), .ctrlIdx(ctrlIdx),
    .hostWrData(hostWrData), .ctrlWrData(ctrlWrData),
    .hostRdData(hostRdData), .ctrlRdData(ctrlRdData),
    .bellQ(bellQ), .respQ(respQ)
  );

  assign hostIrq = respQ;
  assign ctrlIrq = bellQ;

endmodule

// File: tb/tb_hb_mailbox.sv
`timescale 1ns/1ps
module tb_hb_mailbox;

  localparam int BASE = 16'h0C00;
  localparam int WIN  = 32;
  localparam int ND   = 16;
  localparam int BELL = 16;
  localparam int RESP = 17;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] hostAddr = '0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0]  hostWrData = '0, hostRdData;
  logic [4:0]  ctrlAddr = '0;
  logic        ctrlWr = 1'b0, ctrlRd = 1'b0;
  logic [7:0]  ctrlWrData = '0, ctrlRdData;
  logic        hostIrq, ctrlIrq;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  logic [7:0] mData [ND];
  logic       mBell, mResp;

  always #4 clk = ~clk;

  hb_mailbox dut (
    .clk(clk), .rstN(rstN),
    .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .ctrlAddr(ctrlAddr), .ctrlWr(ctrlWr), .ctrlRd(ctrlRd),
    .ctrlWrData(ctrlWrData), .ctrlRdData(ctrlRdData),
    .hostIrq(hostIrq), .ctrlIrq(ctrlIrq)
  );

  function automatic logic [7:0] expOff(input int off);
    if (off < ND)         return mData[off];
    else if (off == BELL) return {7'd0, mBell};
    else if (off == RESP) return {7'd0, mResp};
    else                  return 8'd0;
  endfunction

  function automatic int hostRel(input logic [15:0] a);
    return int'(a) - BASE;
  endfunction

  function automatic bit inWin(input logic [15:0] a);
    return hostRel(a) >= 0 && hostRel(a) < WIN;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag,
                      input bit hW, input bit hR, input logic [15:0] hA, input logic [7:0] hD,
                      input bit cW, input bit cR, input logic [4:0] cA, input logic [7:0] cD);
    logic [7:0] eH, eC;
    int rel;
    @(negedge clk);
    hostWr = hW; hostRd = hR; hostAddr = hA; hostWrData = hD;
    ctrlWr = cW; ctrlRd = cR; ctrlAddr = cA; ctrlWrData = cD;
    rel = hostRel(hA);
    eH = (hR && inWin(hA)) ? expOff(rel) : 8'd0;
    eC = cR ? expOff(int'(cA)) : 8'd0;
    if (hW && inWin(hA) && rel < ND) mData[rel] = hD;
    if (cW && int'(cA) < ND) mData[cA] = cD;
    if (cW && int'(cA) == BELL && cD[0]) mBell = 1'b0;
    if (hW && inWin(hA) && rel == BELL) mBell = hD[0];
    if (hW && inWin(hA) && rel == RESP && hD[0]) mResp = 1'b0;
    if (cW && int'(cA) == RESP && cD[0]) mResp = 1'b1;
    @(posedge clk);
    #1;
    chk(tag, "hostRdData", int'(hostRdData), int'(eH));
    chk(tag, "ctrlRdData", int'(ctrlRdData), int'(eC));
    chk(tag, "hostIrq", int'(hostIrq), int'(mResp));
    chk(tag, "ctrlIrq", int'(ctrlIrq), int'(mBell));
    hostWr = 1'b0; hostRd = 1'b0; ctrlWr = 1'b0; ctrlRd = 1'b0;
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    for (int i = 0; i < ND; i++) mData[i] = 8'd0;
    mBell = 1'b0; mResp = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state seen through both ports
    for (int i = 0; i < 18; i++)
      step("R1", 0, 1, 16'(BASE + i), 0, 0, 1, 5'(i), 0);

    // R2: host writes a request, controller reads it back
    for (int i = 0; i < ND; i++)
      step("R2", 1, 0, 16'(BASE + i), 8'(8'h30 + i), 0, 0, 0, 0);
    for (int i = 0; i < ND; i++)
      step("R2", 0, 0, 0, 0, 0, 1, 5'(i), 0);
    // R2: controller reply read by host
    for (int i = 0; i < ND; i++)
      step("R2", 0, 0, 0, 0, 1, 0, 5'(i), 8'(8'hA0 ^ i));
    for (int i = 0; i < ND; i++)
      step("R2", 0, 1, 16'(BASE + i), 0, 0, 0, 0, 0);

    // R3: same-offset collision keeps the controller byte
    step("R3", 1, 0, 16'(BASE + 5), 8'h11, 1, 0, 5'd5, 8'h22);
    step("R3", 0, 1, 16'(BASE + 5), 0, 0, 1, 5'd5, 0);

    // R4: doorbell ring and withdraw
    step("R4", 1, 0, 16'(BASE + BELL), 8'h01, 0, 0, 0, 0);
    step("R4", 0, 1, 16'(BASE + BELL), 0, 0, 1, 5'(BELL), 0);
    step("R4", 1, 0, 16'(BASE + BELL), 8'hFE, 0, 0, 0, 0);
    // R5: controller clear, no-op, and host priority
    step("R5", 1, 0, 16'(BASE + BELL), 8'h01, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 0, 1, 0, 5'(BELL), 8'hFE);
    step("R5", 0, 0, 0, 0, 1, 0, 5'(BELL), 8'h01);
    step("R5", 1, 0, 16'(BASE + BELL), 8'h01, 1, 0, 5'(BELL), 8'h01);

    // R6: controller sets response; no-op with bit0 clear
    step("R6", 0, 0, 0, 0, 1, 0, 5'(RESP), 8'hFE);
    step("R6", 0, 0, 0, 0, 1, 0, 5'(RESP), 8'h01);
    // R8: status read layout
    step("R8", 0, 1, 16'(BASE + RESP), 0, 0, 1, 5'(RESP), 0);
    // R7: host zero write no-op, set beats clear, then clear
    step("R7", 1, 0, 16'(BASE + RESP), 8'hFE, 0, 0, 0, 0);
    step("R7", 1, 0, 16'(BASE + RESP), 8'h01, 1, 0, 5'(RESP), 8'h01);
    step("R7", 1, 0, 16'(BASE + RESP), 8'hFF, 0, 0, 0, 0);

    // R9: unused offsets and outside the window
    step("R9", 1, 0, 16'(BASE + 20), 8'h77, 1, 0, 5'd31, 8'h77);
    step("R9", 0, 1, 16'(BASE + 20), 0, 0, 1, 5'd31, 0);
    step("R9", 1, 0, 16'(BASE + WIN), 8'h99, 0, 0, 0, 0);
    step("R9", 1, 0, 16'(BASE - 1), 8'h99, 0, 0, 0, 0);
    step("R9", 1, 0, 16'(BASE + WIN + BELL), 8'h01, 0, 0, 0, 0);
    step("R9", 0, 1, 16'(BASE + WIN), 0, 0, 1, 5'd0, 0);
    step("R9", 0, 1, 16'(BASE), 0, 0, 1, 5'(BELL), 0);

    // R10: read during write returns old value
    step("R10", 1, 1, 16'(BASE + 3), 8'h5A, 0, 1, 5'd3, 0);
    step("R10", 0, 1, 16'(BASE + 3), 0, 1, 1, 5'd3, 8'hC3);
    step("R10", 0, 1, 16'(BASE + 3), 0, 0, 0, 0, 0);

    // Random mix over both ports (R2 R3 R4 R5 R6 R7 R8 R9 R10)
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      a = 16'(BASE - 4 + int'($urandom % 40));
      step("R2", bit'($urandom % 2), bit'($urandom % 2), a, 8'($urandom),
           bit'($urandom % 2), bit'($urandom % 2), 5'($urandom % 20), 8'($urandom));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule